// File: doc/BRIEF.md
# Windowed Edge Counting Timer Channel

This block is a single timer channel that counts qualified transitions of an event input while a time window is open. The window is defined by two compare values checked against a shared free-running timebase. When the timebase equals the start value, the internal event counter is cleared and the window opens. When the timebase later equals the stop value, the window closes, the accumulated count is latched into a capture register, and the channel flag rises.

Software configures the channel through a small register bus with four word addresses: start/capture, stop, control and status. The start/capture address is aliased asymmetrically: a write programs the start compare and arms the channel, while a read returns the captured count. In continuous operation every start match after arming reopens the window. In single-shot operation one completed window disarms the channel until the start value is written again. The event input is expected to be synchronised and filtered before it reaches this block.

Top module: `wincnt_chan`

## Requirements
- R1: After a synchronous reset, the flag output is 0, and the capture, stop and control registers all read back as 0.
- R2: Register map by word address. Address 0 write sets the start compare and arms the channel, and a read returns the capture register. Address 1 is the stop compare, readable and writable. Address 2 is control: bits [6:0] mode, bit 8 both-edges select, bit 9 polarity, readable and writable. Address 3 read bit 0 is the flag. Read data appears on `bus_rdata` one clock after the cycle that presents the read request.
- R3: Mode code 7'b0001010 selects continuous operation and 7'b0001011 selects single-shot. Any other mode code opens no window and never sets the flag.
- R4: With bit 8 set, every change of the event input is counted. With bit 8 clear, only rising transitions are counted when bit 9 is 1, and only falling transitions when bit 9 is 0.
- R5: The window opens in the cycle the timebase equals the start value while the channel is armed and no window is open. That cycle clears the counter, and an edge arriving in that cycle is not counted. Counting starts on the following cycle.
- R6: While the window is open, the cycle in which the timebase equals the stop value closes the window, sets the flag, and loads the capture register with the count including any edge in that same cycle. The capture register changes at no other time.
- R7: In single-shot mode, a completed window disarms the channel. Later start matches are then ignored until address 0 is written again.
- R8: In continuous mode, after one completed window, the next start match reopens the window without any new write.
- R9: Writing 1 to bit 0 at address 3 clears the flag. If a stop match happens in the same cycle as that write, the flag stays set.
- R10: The event counter holds at its all-ones value instead of wrapping, and it does not change outside an open window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read request |
| bus_wdata | input | BUS_W (32) | Write data |
| bus_rdata | output | BUS_W (32) | Registered read data |
| tb_val | input | TB_W (24) | Shared timebase value |
| evt_in | input | 1 | Synchronised, filtered event input |
| flag_o | output | 1 | Channel flag / interrupt request |

## Verification
The timebase, the event level and any register write are all taken at one rising edge. The flag and the capture register for a stop match are due right after the edge at which the timebase equals the stop value, and a read request gives its data one edge later. The bench drives every input at a falling edge. It samples the flag at the next falling edge, and it reads the capture register only after the sweep has moved the timebase off the stop value, so each check falls exactly one register stage after its cause. Because the bench drives the timebase directly, it can hold one value to build up more than a thousand edges for the saturation case. It can also line a flag-clear write up with the stop-match cycle.

// File: rtl/wincnt_pkg.sv
package wincnt_pkg;
  localparam logic [6:0] MODE_CONT = 7'b0001010;
  localparam logic [6:0] MODE_SHOT = 7'b0001011;
  localparam int CTRL_BOTH_BIT = 8;
  localparam int CTRL_POL_BIT  = 9;

  typedef enum logic [1:0] {
    ADR_START = 2'd0,
    ADR_STOP  = 2'd1,
    ADR_CTRL  = 2'd2,
    ADR_STAT  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/wincnt_edge.sv
module wincnt_edge (
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic both,
  input  logic pol,
  output logic hit
);
  logic evt_d;

  always_ff @(posedge clk) begin
    if (rst) evt_d <= 1'b0;
    else     evt_d <= evt;
  end

  // a change is qualified when both edges count, or when its new level matches polarity
  always_comb begin
    hit = (evt ^ evt_d) && (both || (evt == pol));
  end
endmodule

// File: rtl/wincnt_regs.sv
module wincnt_regs
  import wincnt_pkg::*;
#(
  parameter int TB_W  = 24,
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       addr,
  input  logic             wr,
  input  logic             rd,
  input  logic [BUS_W-1:0] wdata,
  input  logic [TB_W-1:0]  cap_val,
  input  logic             flag,
  output logic [BUS_W-1:0] rdata,
  output logic [TB_W-1:0]  start_q,
  output logic [TB_W-1:0]  stop_q,
  output logic [6:0]       mode_q,
  output logic             both_q,
  output logic             pol_q,
  output logic             arm_wr,
  output logic             flag_clr
);
  logic [BUS_W-1:0] rd_mux;
  logic             unused_hi;

  assign unused_hi = ^wdata[BUS_W-1:TB_W];

  always_comb begin
    arm_wr   = wr && (reg_addr_e'(addr) == ADR_START);
    flag_clr = wr && (reg_addr_e'(addr) == ADR_STAT) && wdata[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      stop_q  <= '0;
      mode_q  <= '0;
      both_q  <= 1'b0;
      pol_q   <= 1'b0;
    end else if (wr) begin
      case (reg_addr_e'(addr))
        ADR_START: start_q <= wdata[TB_W-1:0];
        ADR_STOP:  stop_q  <= wdata[TB_W-1:0];
        ADR_CTRL: begin
          mode_q <= wdata[6:0];
          both_q <= wdata[CTRL_BOTH_BIT];
          pol_q  <= wdata[CTRL_POL_BIT];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr_e'(addr))
      ADR_START: rd_mux[TB_W-1:0] = cap_val;
      ADR_STOP:  rd_mux[TB_W-1:0] = stop_q;
      ADR_CTRL: begin
        rd_mux[6:0]           = mode_q;
        rd_mux[CTRL_BOTH_BIT] = both_q;
        rd_mux[CTRL_POL_BIT]  = pol_q;
      end
      default:   rd_mux[0] = flag;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end

  AST_RD_STOP: assert property (@(posedge clk) disable iff (rst)
    (rd && addr == 2'd1 && !wr) |=> rdata[TB_W-1:0] == $past(stop_q)); // R2
endmodule

// File: rtl/wincnt_core.sv
module wincnt_core
  import wincnt_pkg::*;
#(
  parameter int TB_W = 24
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [TB_W-1:0] tb,
  input  logic [TB_W-1:0] start_val,
  input  logic [TB_W-1:0] stop_val,
  input  logic [6:0]      mode,
  input  logic            arm_wr,
  input  logic            evt_hit,
  input  logic            flag_clr,
  output logic [TB_W-1:0] cap_q,
  output logic            flag_q
);
  localparam logic [TB_W-1:0] CNT_MAX = {TB_W{1'b1}};

  logic            enabled, single;
  logic            armed_q, win_q;
  logic [TB_W-1:0] cnt_q;
  logic            start_hit, stop_hit, cnt_inc;

  always_comb begin
    enabled   = (mode[6:1] == MODE_CONT[6:1]);
    single    = mode[0];
    start_hit = enabled && armed_q && !win_q && (tb == start_val);
    stop_hit  = enabled && win_q && (tb == stop_val);
    cnt_inc   = win_q && evt_hit && (cnt_q != CNT_MAX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      win_q   <= 1'b0;
    end else begin
      if (arm_wr)                  armed_q <= 1'b1;
      else if (stop_hit && single) armed_q <= 1'b0;
      if (!enabled || stop_hit)    win_q <= 1'b0;
      else if (start_hit)          win_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            cnt_q <= '0;
    else if (start_hit) cnt_q <= '0;
    else if (cnt_inc)   cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (stop_hit) cap_q <= cnt_inc ? cnt_q + 1'b1 : cnt_q;
      if (stop_hit)      flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  AST_FLAG_FROM_STOP: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(stop_hit)); // R6
  AST_CAP_ONLY_ON_STOP: assert property (@(posedge clk) disable iff (rst)
    !stop_hit |=> $stable(cap_q)); // R6
  AST_SHOT_NO_REOPEN: assert property (@(posedge clk) disable iff (rst)
    !armed_q |=> !$rose(win_q)); // R7
  AST_CLR_LOSES: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && stop_hit) |=> flag_q); // R9
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX && !start_hit) |=> cnt_q == CNT_MAX); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!win_q && !start_hit) |=> $stable(cnt_q)); // R10
endmodule

// File: rtl/wincnt_chan.sv
module wincnt_chan #(
  parameter int TB_W  = 24,
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic [TB_W-1:0]  tb_val,
  input  logic             evt_in,
  output logic             flag_o
);
  logic [TB_W-1:0] start_q, stop_q, cap_q;
  logic [6:0]      mode_q;
  logic            both_q, pol_q, arm_wr, flag_clr, evt_hit, flag_q;

  wincnt_regs #(.TB_W(TB_W), .BUS_W(BUS_W)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .cap_val(cap_q), .flag(flag_q), .rdata(bus_rdata),
    .start_q(start_q), .stop_q(stop_q), .mode_q(mode_q), .both_q(both_q),
    .pol_q(pol_q), .arm_wr(arm_wr), .flag_clr(flag_clr)
  );

  wincnt_edge u_edge (
    .clk(clk), .rst(rst), .evt(evt_in), .both(both_q), .pol(pol_q), .hit(evt_hit)
  );

  wincnt_core #(.TB_W(TB_W)) u_core (
    .clk(clk), .rst(rst), .tb(tb_val), .start_val(start_q), .stop_val(stop_q),
    .mode(mode_q), .arm_wr(arm_wr), .evt_hit(evt_hit), .flag_clr(flag_clr),
    .cap_q(cap_q), .flag_q(flag_q)
  );

  assign flag_o = flag_q;
endmodule

// File: tb/wincnt_chan_bench.sv
module wincnt_chan_bench;
  localparam int TB_W  = 10;
  localparam int BUS_W = 32;
  localparam int IDLE  = 'h300;
  localparam int S0    = 'h20;
  localparam int E0    = 'h40;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [1:0]       bus_addr = '0;
  logic             bus_wr = 1'b0;
  logic             bus_rd = 1'b0;
  logic [BUS_W-1:0] bus_wdata = '0;
  logic [BUS_W-1:0] bus_rdata;
  logic [TB_W-1:0]  tb_val = IDLE[TB_W-1:0];
  logic             evt_in = 1'b0;
  logic             flag_o;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 0;
  bit  m_both   = 0;
  bit  m_pol    = 0;

  always #2 clk = ~clk;

  wincnt_chan #(.TB_W(TB_W), .BUS_W(BUS_W)) u_wincnt_chan (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tb_val(tb_val),
    .evt_in(evt_in), .flag_o(flag_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input int d);
    @(negedge clk);
    bus_addr = a[1:0]; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int a, output int d);
    @(negedge clk);
    bus_addr = a[1:0]; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = int'(bus_rdata);
  endtask

  task automatic set_ctrl(input int mode, input bit both, input bit pol);
    m_both = both; m_pol = pol;
    bus_write(2, mode | (int'(both) << 8) | (int'(pol) << 9));
  endtask

  function automatic bit qual(bit p, bit v);
    if (p == v) return 1'b0;
    if (m_both) return 1'b1;
    return v == m_pol;
  endfunction

  // toggle the event every cycle while the timebase steps lo..hi; model counts (s, e]
  task automatic sweep(input int s, input int e, input int lo, input int hi, output int n);
    n = 0;
    for (int t = lo; t <= hi; t++) begin
      bit p;
      @(negedge clk);
      tb_val = t[TB_W-1:0];
      p = evt_in;
      evt_in = ~evt_in;
      if (t > s && t <= e && qual(p, evt_in)) n++;
    end
    @(negedge clk);
    tb_val = IDLE[TB_W-1:0];
  endtask

  task automatic t_reset();
    int d;
    chk("R1 flag after reset", int'(flag_o), 0);
    bus_read(0, d); chk("R1 capture after reset", d, 0);
    bus_read(1, d); chk("R1 stop after reset", d, 0);
    bus_read(2, d); chk("R1 control after reset", d, 0);
  endtask

  task automatic t_regmap();
    int d;
    set_ctrl('h0A, 0, 1);
    bus_write(1, E0);
    bus_read(1, d); chk("R2 stop readback", d, E0);
    bus_read(2, d); chk("R2 control readback", d, 'h20A);
  endtask

  task automatic t_rising_cont();
    int n, d;
    bus_write(0, S0);
    sweep(S0, E0, S0 - 2, E0 + 2, n);
    chk("R6 flag after stop match", int'(flag_o), 1);
    bus_read(0, d); chk("R4 R5 rising count", d, n);
    bus_read(3, d); chk("R2 status flag bit", d, 1);
    bus_write(3, 1);
    chk("R9 flag cleared by write", int'(flag_o), 0);
  endtask

  task automatic t_cont_reopen();
    int n, d;
    set_ctrl('h0A, 0, 0);
    sweep(S0, E0, S0 - 2, E0 + 2, n);
    chk("R8 continuous reopen flag", int'(flag_o), 1);
    bus_read(0, d); chk("R8 R4 falling count", d, n);
    bus_write(3, 1);
  endtask

  task automatic t_both_edges();
    int n, d;
    set_ctrl('h0A, 1, 0);
    bus_write(0, S0);
    sweep(S0, E0, S0 - 2, E0 + 2, n);
    bus_read(0, d); chk("R4 both edges count", d, n);
    chk("R4 both edges count value", d, E0 - S0);
    bus_write(3, 1);
  endtask

  task automatic t_single_shot();
    int n1, n2, d;
    set_ctrl('h0B, 0, 1);
    bus_write(0, S0);
    sweep(S0, E0, S0 - 2, E0 + 2, n1);
    chk("R7 single-shot first flag", int'(flag_o), 1);
    bus_read(0, d); chk("R7 single-shot first count", d, n1);
    bus_write(3, 1);
    set_ctrl('h0B, 1, 0);
    sweep(S0, E0, S0 - 2, E0 + 2, n2);
    chk("R7 no reopen without write", int'(flag_o), 0);
    bus_read(0, d); chk("R7 capture held", d, n1);
    bus_write(0, S0);
    sweep(S0, E0, S0 - 2, E0 + 2, n2);
    chk("R7 rearmed flag", int'(flag_o), 1);
    bus_read(0, d); chk("R7 rearmed count", d, n2);
    bus_write(3, 1);
  endtask

  task automatic t_disabled(input int prev);
    int n, d;
    set_ctrl('h00, 1, 0);
    bus_write(0, S0);
    sweep(S0, E0, S0 - 2, E0 + 2, n);
    chk("R3 other mode sets no flag", int'(flag_o), 0);
    bus_read(0, d); chk("R3 other mode keeps capture", d, prev);
  endtask

  task automatic t_start_stop_edges();
    int d;
    set_ctrl('h0A, 0, 1);
    bus_write(0, S0);
    @(negedge clk); evt_in = 1'b0; tb_val = IDLE[TB_W-1:0];
    @(negedge clk); evt_in = 1'b1; tb_val = S0[TB_W-1:0];
    @(negedge clk); evt_in = 1'b0; tb_val = S0[TB_W-1:0] + 1'b1;
    @(negedge clk); evt_in = 1'b1; tb_val = E0[TB_W-1:0];
    @(negedge clk); tb_val = IDLE[TB_W-1:0];
    chk("R6 flag on stop cycle", int'(flag_o), 1);
    bus_read(0, d); chk("R5 R6 start edge out, stop edge in", d, 1);
    bus_write(3, 1);
  endtask

  task automatic t_clear_collision();
    int n, d;
    set_ctrl('h0A, 1, 0);
    bus_write(0, S0);
    sweep(S0, E0, S0 - 2, E0 - 1, n);
    @(negedge clk);
    tb_val = E0[TB_W-1:0]; bus_addr = 2'd3; bus_wdata = 1; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tb_val = IDLE[TB_W-1:0];
    chk("R9 stop beats clear", int'(flag_o), 1);
    bus_read(0, d); chk("R9 count at collision", d, n);
    bus_write(3, 1);
    chk("R9 later clear works", int'(flag_o), 0);
  endtask

  task automatic t_saturate();
    int d;
    set_ctrl('h0A, 1, 0);
    bus_write(0, S0);
    @(negedge clk); tb_val = S0[TB_W-1:0];
    @(negedge clk); tb_val = S0[TB_W-1:0] + 1'b1;
    for (int i = 0; i < 1100; i++) begin
      @(negedge clk); evt_in = ~evt_in;
    end
    @(negedge clk); tb_val = E0[TB_W-1:0];
    @(negedge clk); tb_val = IDLE[TB_W-1:0];
    chk("R10 flag after long window", int'(flag_o), 1);
    bus_read(0, d); chk("R10 count saturates", d, (1 << TB_W) - 1);
    bus_write(3, 1);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
  endtask

  initial begin
    int d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_rising_cont();
    t_cont_reopen();
    t_both_edges();
    t_single_shot();
    bus_read(0, d);
    t_disabled(d);
    t_start_stop_edges();
    t_clear_collision();
    t_saturate();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog R1..: run did not complete");
      summary();
      $finish;
    end
  end
endmodule